// File: doc/BRIEF.md
# GPIO Port with Level-Match Interrupts

This block is a memory-mapped port of fourteen pins. Software controls it through six word registers on a simple strobe bus. Each pin works either as a software GPIO or as the pin of a fixed peripheral function. In GPIO mode, software sets the pin's direction and its output value. In peripheral mode, the peripheral drives the output value, and a hard-wired per-pin table picks the direction. The direction register has no effect on a pin in peripheral mode.

Pad inputs pass through a two-flop synchronizer. The synchronized values are returned on data reads, are sent to the peripheral inputs, and are compared with a per-pin level register. When a pin's value matches its level, its status bit latches and stays set until software clears it. A per-pin enable register routes each pending bit either to the non-maskable interrupt output or to the normal interrupt output.

The register bus has no back-pressure. A write completes in its strobe cycle. A read always returns its data one cycle after its strobe. Pad, peripheral and interrupt pins are plain levels.

Top module: `gpio_lvlmatch`

## Requirements
- R1: While reset is asserted and directly after it, every register is zero: pad_oe and pad_out are 0, and irq and nmi are low. The function and direction registers read back as 0.
- R2: The byte offsets are 0x00 function select, 0x04 direction, 0x08 data, 0x0C interrupt level, 0x10 interrupt status and 0x14 NMI enable. A write takes effect at the edge where bus_wr is high. bus_rdata holds the addressed value in the cycle after bus_rd. Offsets above 0x14 read as zero, and writes to them change nothing.
- R3: Only bits 13:0 exist. Bits 31:14 of every read are zero, and writing those bits has no effect.
- R4: A pin whose function bit is 0 is a GPIO. Its pad_oe equals its direction bit (1 = output), and its pad_out equals its data-register bit.
- R5: A pin whose function bit is 1 drives its alt_out bit on pad_out. Its pad_oe is forced to 1 for pins 0, 2, 4, 5, 6, 7, 8, 10, 12 and 13 (mask 0x35F5) and to 0 for pins 1, 3, 9 and 11. The direction bit has no effect on such a pin.
- R6: pad_in reaches the data-register readback and alt_in through exactly two flops. A change becomes visible on alt_in after the second rising edge.
- R7: A status bit sets on the edge after the synchronized pin equals the pin's level bit. It stays set after the match goes away.
- R8: Writing 1 to a status bit clears it. Writing 0 has no effect. If the match still holds, the bit sets again one cycle after the clear.
- R9: nmi is the OR of the status bits whose NMI-enable bit is 1. irq is the OR of the status bits whose enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| pad_in | input | 14 | Raw pad input levels |
| pad_out | output | 14 | Pad output values |
| pad_oe | output | 14 | Pad output enables |
| alt_out | input | 14 | Output values from the peripheral functions |
| alt_in | output | 14 | Synchronized pad values sent to the peripheral functions |
| irq | output | 1 | Normal interrupt |
| nmi | output | 1 | Non-maskable interrupt |

## Verification
The embedded assertions check four things on every cycle:
- the two-stage synchronizer latency;
- that a status bit never drops except through a clear written to it;
- that a written clear takes effect;
- that a register write lands and every read returns zero in bits 31:14.

Other behaviours depend on specific register settings, so only the bench scenarios show them:
- the forced direction table for peripheral mode;
- a direction or data setting having no effect on a pin in peripheral mode;
- a bit setting again after a clear while its match persists;
- interrupts being routed between irq and nmi by the enable mask.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
  localparam int BUS_DW = 32;
  localparam int BUS_AW = 5;

  typedef enum logic [2:0] {
    RG_FUNC = 3'd0,
    RG_DIR  = 3'd1,
    RG_DATA = 3'd2,
    RG_LVL  = 3'd3,
    RG_STAT = 3'd4,
    RG_NMIE = 3'd5
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;
  logic [1:0]   age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
      age    <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  assign q = stage2;

  // R6
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> (q == $past(d, 2)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_lvl_pkg::*;
#(
  parameter int NPINS = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_s,
  input  logic [NPINS-1:0]  stat,
  output logic [NPINS-1:0]  func,
  output logic [NPINS-1:0]  dir,
  output logic [NPINS-1:0]  dout,
  output logic [NPINS-1:0]  lvl,
  output logic [NPINS-1:0]  nmie,
  output logic [NPINS-1:0]  clr
);
  localparam int IDX_W = BUS_AW - 2;

  logic [IDX_W-1:0] idx;
  logic [NPINS-1:0] wbits, rsel;
  logic             unused_bits;

  assign idx         = bus_addr[BUS_AW-1:2];
  assign wbits       = bus_wdata[NPINS-1:0];
  assign unused_bits = ^{bus_wdata[BUS_DW-1:NPINS], bus_addr[1:0]};
  assign clr         = (bus_wr && idx == RG_STAT) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      func <= '0;
      dir  <= '0;
      dout <= '0;
      lvl  <= '0;
      nmie <= '0;
    end else if (bus_wr) begin
      case (idx)
        RG_FUNC: func <= wbits;
        RG_DIR:  dir  <= wbits;
        RG_DATA: dout <= wbits;
        RG_LVL:  lvl  <= wbits;
        RG_NMIE: nmie <= wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      RG_FUNC: rsel = func;
      RG_DIR:  rsel = dir;
      RG_DATA: rsel = pin_s;
      RG_LVL:  rsel = lvl;
      RG_STAT: rsel = stat;
      RG_NMIE: rsel = nmie;
      default: rsel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= {{(BUS_DW-NPINS){1'b0}}, rsel};
  end

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_rdata[BUS_DW-1:NPINS] == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == RG_DIR) |=> (dir == $past(bus_wdata[NPINS-1:0])));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
  parameter int               NPINS       = 14,
  parameter logic [NPINS-1:0] ALT_OE_MASK = 14'h35F5
) (
  input  logic [NPINS-1:0] func,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] dout,
  input  logic [NPINS-1:0] alt_out,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pad_oe[i]  = func[i] ? ALT_OE_MASK[i] : dir[i];
    assign pad_out[i] = func[i] ? alt_out[i]     : dout[i];
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int NPINS = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_s,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] clr,
  input  logic [NPINS-1:0] nmie,
  output logic [NPINS-1:0] stat,
  output logic             irq,
  output logic             nmi
);
  logic [NPINS-1:0] match;

  assign match = ~(pin_s ^ lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat | match) & ~clr;
  end

  assign nmi = |(stat & nmie);
  assign irq = |(stat & ~nmie);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & ~clr)) |=> ((stat & $past(stat & ~clr)) == $past(stat & ~clr)));

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |=> ((stat & $past(clr)) == '0));
endmodule

// File: rtl/gpio_lvlmatch.sv
module gpio_lvlmatch
  import gpio_lvl_pkg::*;
#(
  parameter int               NPINS       = 14,
  parameter logic [NPINS-1:0] ALT_OE_MASK = 14'h35F5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_DW-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  input  logic [NPINS-1:0]  alt_out,
  output logic [NPINS-1:0]  alt_in,
  output logic              irq,
  output logic              nmi
);
  logic [NPINS-1:0] pin_s, stat, func, dir, dout, lvl, nmie, clr;

  gpio_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_s(pin_s), .stat(stat), .func(func), .dir(dir), .dout(dout),
    .lvl(lvl), .nmie(nmie), .clr(clr)
  );

  gpio_pinmux #(.NPINS(NPINS), .ALT_OE_MASK(ALT_OE_MASK)) u_mux (
    .func(func), .dir(dir), .dout(dout), .alt_out(alt_out),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .lvl(lvl), .clr(clr),
    .nmie(nmie), .stat(stat), .irq(irq), .nmi(nmi)
  );

  assign alt_in = pin_s;
endmodule

// File: tb/gpio_lvlmatch_tb.sv
`timescale 1ns/1ps
module gpio_lvlmatch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [13:0] pad_in = '0;
  logic [13:0] pad_out, pad_oe;
  logic [13:0] alt_out = '0;
  logic [13:0] alt_in;
  logic        irq, nmi;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  gpio_lvlmatch u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_in(alt_in), .irq(irq), .nmi(nmi)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver tasks: called at a falling edge, return at a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: read data is valid the cycle after the strobe
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R2: unexpected read data %h expected none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    chk("R1 oe", {18'd0, pad_oe}, 32'h0);
    chk("R1 out", {18'd0, pad_out}, 32'h0);
    chk("R1 irq/nmi", {30'd0, irq, nmi}, 32'h0);
    rst_n = 1'b1;
    idle(1);
    rd(5'h00, 32'h0, "R1 func");
    rd(5'h04, 32'h0, "R1 dir");
    idle(2);
    rd(5'h10, 32'h3FFF, "R7 match after reset");

    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, 32'h3FFF, "R3 upper bits");
    wr(5'h04, 32'h0F0F);
    wr(5'h08, 32'h3333);
    chk("R4 oe", {18'd0, pad_oe}, 32'h0F0F);
    chk("R4 out", {18'd0, pad_out}, 32'h3333);
    rd(5'h08, 32'h0, "R6 data reads pins");
    rd(5'h18, 32'h0, "R2 unmapped read");
    wr(5'h18, 32'hFFFF_FFFF);
    rd(5'h00, 32'h0, "R2 unmapped write");

    alt_out = 14'h2AAA;
    wr(5'h00, 32'h3FFF);
    chk("R5 oe all alt", {18'd0, pad_oe}, 32'h35F5);
    chk("R5 out all alt", {18'd0, pad_out}, 32'h2AAA);
    wr(5'h00, 32'h00FF);
    chk("R5 oe mixed", {18'd0, pad_oe}, 32'h0FF5);
    chk("R5 out mixed", {18'd0, pad_out}, 32'h33AA);
    rd(5'h00, 32'h00FF, "R2 func readback");

    pad_in = 14'h1234;
    @(negedge clk);
    chk("R6 one edge", {18'd0, alt_in}, 32'h0);
    @(negedge clk);
    chk("R6 two edges", {18'd0, alt_in}, 32'h1234);
    rd(5'h08, 32'h1234, "R6 data readback");

    wr(5'h0C, 32'h3FFF);
    pad_in = 14'h0005;
    idle(3);
    wr(5'h10, 32'h3FFF);
    rd(5'h10, 32'h0, "R8 cleared");
    rd(5'h10, 32'h0005, "R8 re-set on match");
    wr(5'h10, 32'h0);
    rd(5'h10, 32'h0005, "R8 zero write no effect");
    pad_in = 14'h0;
    idle(4);
    rd(5'h10, 32'h0005, "R7 sticky");

    chk("R9 irq only", {30'd0, irq, nmi}, 32'h2);
    wr(5'h14, 32'h0001);
    chk("R9 both", {30'd0, irq, nmi}, 32'h3);
    wr(5'h14, 32'h0005);
    chk("R9 nmi only", {30'd0, irq, nmi}, 32'h1);
    rd(5'h14, 32'h0005, "R2 nmie readback");
    wr(5'h10, 32'hFFFF_FFFF);
    idle(1);
    chk("R8 clear drops interrupts", {30'd0, irq, nmi}, 32'h0);
    rd(5'h10, 32'h0, "R8 status empty");
    idle(2);

    if (exp_q.size() != 0) begin
      vectors++; fails++;
      $display("FAIL R2: actual %0d reads pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule